// File: doc/BRIEF.md
# SMBus Indexed Block-Transfer Register Slave

This block is a two-wire bus slave that gives a bus master access to a small bank of 8-bit control registers. The master never addresses one register directly. It first sends an index byte. On a write it then sends a length byte and that many data bytes, which land in consecutive registers starting at the index. On a read the master issues a repeated start with the read address. The slave first returns a length byte, which it takes from a fixed register of the bank, and then streams consecutive registers starting at the index until the master declines a byte.

SCL and SDA are sampled with the system clock. Both lines pass through a two-flop synchroniser, and start, stop and clock edges are found on the synchronised copies. SDA is driven through an open-drain enable that pulls the line low. The rest of the chip sees the whole register bank as one flat read-only vector. A transfer of a single register uses the same flows: a write with a length of 01h, or a read that the master ends after the first data byte.

Top module: `smbus_blk_slave`

## Requirements
- R1: The slave acknowledges the 8-bit address byte D2h (7-bit address 69h, write) and D3h (read). Any other address byte gets a NACK (SDA left high in the 9th clock), and the rest of that transfer is ignored.
- R2: In a write, the byte after the address is the starting index and the next byte is a length N. The following data bytes are stored at the index, index+1 and so on, and each one is acknowledged. Bytes are sent MSB first.
- R3: A length byte of 00h is NACKed, and no register changes in that transfer.
- R4: Data bytes beyond the declared length are NACKed and not stored.
- R5: Data bytes aimed past the last register (index 15 with the default 16 registers) are NACKed and not stored. The index never wraps to 0.
- R6: In a read, the first byte the slave returns is the content of register 8. After it come the registers from the index given in the preceding write phase, in increasing order.
- R7: A master NACK after a read byte ends the slave's transmission, and SDA is released from then on. The master may stop after any byte.
- R8: A stop condition inside a byte aborts the transfer without storing the partial byte, and the slave accepts a new transfer afterwards. A start condition always restarts address reception.
- R9: SDA is pulled low only in an acknowledge bit or a read-data bit, and the pull-down changes only while SCL is low.
- R10: After reset all registers read 00h and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pulls SDA low when 1 (open drain) |
| reg_bank | output | NUM_REGS*8 | Flat view of all registers; register i occupies bits [8i+7:8i] |

## Verification
The assertions assume that every SCL high and low phase lasts well beyond the synchroniser delay of a few system clocks. They also assume that the master moves SDA only while SCL is low, except when it makes a start or a stop. Under these conditions the slave's own SDA changes always fall inside an SCL low phase, and the first condition seen while SCL is high is the master's. The bench drives the bus with a quarter-bit period of ten system clocks, so each phase is far longer than the synchroniser delay. It changes data only in the middle of the low phase and keeps SDA edges during SCL high for its start and stop tasks.

// File: rtl/smb_pkg.sv
`timescale 1ns/1ps
package smb_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACKW,
        S_ACKD,
        S_TX,
        S_TXA,
        S_TXH,
        S_WAIT
    } smb_state_e;

    typedef enum logic [1:0] {
        B_ADDR,
        B_INDEX,
        B_LEN,
        B_DATA
    } smb_role_e;

    typedef struct packed {
        logic              we;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } smb_wr_t;

    function automatic logic idx_in_bank(input logic [BYTE_W-1:0] a, input int unsigned n);
        return 32'(a) < n;
    endfunction

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic [6:0] dev);
        return b[7:1] == dev;
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
`timescale 1ns/1ps
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_d  <= scl_ff[STAGES-1];
            sda_d  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smb_regfile.sv
`timescale 1ns/1ps
module smb_regfile
    import smb_pkg::*;
#(
    parameter int NUM_REGS  = 16,
    parameter int COUNT_REG = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  smb_wr_t                  wr,
    input  logic [BYTE_W-1:0]        raddr,
    output logic [BYTE_W-1:0]        rd_data,
    output logic [BYTE_W-1:0]        len_data,
    output logic [NUM_REGS*BYTE_W-1:0] bank
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [BYTE_W-1:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (wr.we && (32'(wr.addr) == i)) begin
                regs[i] <= wr.data;
            end
        end
        assign bank[i*BYTE_W +: BYTE_W] = regs[i];
    end

    always_comb begin
        rd_data = 8'hFF;
        if (idx_in_bank(raddr, NUM_REGS)) begin
            rd_data = regs[raddr[IDX_W-1:0]];
        end
    end

    assign len_data = regs[COUNT_REG];
endmodule

// File: rtl/smb_ctrl.sv
`timescale 1ns/1ps
module smb_ctrl
    import smb_pkg::*;
#(
    parameter int         NUM_REGS = 16,
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic [BYTE_W-1:0] len_data,
    output smb_wr_t           wr,
    output logic [BYTE_W-1:0] raddr,
    output logic              sda_oe,
    output smb_state_e        state_o
);
    smb_state_e        state;
    smb_role_e         role;
    logic [2:0]        bitn;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] ptr;
    logic [BYTE_W-1:0] remain;
    logic              ack_q;
    logic              next_tx;
    logic [BYTE_W-1:0] rx_byte;
    logic              ptr_ok;

    assign rx_byte = {shreg[6:0], sda_s};
    assign ptr_ok  = idx_in_bank(ptr, NUM_REGS);
    assign raddr   = ptr;
    assign state_o = state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            role    <= B_ADDR;
            bitn    <= '0;
            shreg   <= '0;
            ptr     <= '0;
            remain  <= '0;
            ack_q   <= 1'b0;
            next_tx <= 1'b0;
            wr      <= '0;
        end else begin
            wr.we <= 1'b0;
            if (start_det) begin
                state <= S_RX;
                role  <= B_ADDR;
                bitn  <= '0;
            end else if (stop_det) begin
                state <= S_IDLE;
            end else begin
                unique case (state)
                    S_RX: if (scl_rise) begin
                        shreg <= rx_byte;
                        bitn  <= bitn + 3'd1;
                        if (bitn == 3'd7) begin
                            state   <= S_ACKW;
                            ack_q   <= 1'b0;
                            next_tx <= 1'b0;
                            unique case (role)
                                B_ADDR: if (addr_hit(rx_byte, DEV_ADDR)) begin
                                    ack_q <= 1'b1;
                                    if (rx_byte[0]) next_tx <= 1'b1;
                                    else            role    <= B_INDEX;
                                end
                                B_INDEX: begin
                                    ptr   <= rx_byte;
                                    ack_q <= 1'b1;
                                    role  <= B_LEN;
                                end
                                B_LEN: if (rx_byte != '0) begin
                                    remain <= rx_byte;
                                    ack_q  <= 1'b1;
                                    role   <= B_DATA;
                                end
                                B_DATA: if ((remain != '0) && ptr_ok) begin
                                    wr.we   <= 1'b1;
                                    wr.addr <= ptr;
                                    wr.data <= rx_byte;
                                    ptr     <= ptr + 8'd1;
                                    remain  <= remain - 8'd1;
                                    ack_q   <= 1'b1;
                                end
                                default: ;
                            endcase
                        end
                    end
                    S_ACKW: if (scl_fall) state <= S_ACKD;
                    S_ACKD: if (scl_fall) begin
                        bitn <= '0;
                        if (!ack_q) begin
                            state <= S_WAIT;
                        end else if (next_tx) begin
                            state <= S_TX;
                            shreg <= len_data;
                        end else begin
                            state <= S_RX;
                        end
                    end
                    S_TX: if (scl_fall) begin
                        if (bitn == 3'd7) begin
                            state <= S_TXA;
                        end else begin
                            shreg <= {shreg[6:0], 1'b0};
                            bitn  <= bitn + 3'd1;
                        end
                    end
                    S_TXA: if (scl_rise) begin
                        if (sda_s) begin
                            state <= S_WAIT;
                        end else begin
                            shreg <= rd_data;
                            if (ptr_ok) ptr <= ptr + 8'd1;
                            state <= S_TXH;
                        end
                    end
                    S_TXH: if (scl_fall) begin
                        state <= S_TX;
                        bitn  <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe = ((state == S_ACKD) && ack_q) || ((state == S_TX) && !shreg[7]);
endmodule

// File: rtl/smbus_blk_slave.sv
`timescale 1ns/1ps
module smbus_blk_slave
    import smb_pkg::*;
#(
    parameter int         NUM_REGS    = 16,
    parameter int         COUNT_REG   = 8,
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        scl_i,
    input  logic                        sda_i,
    output logic                        sda_oe,
    output logic [NUM_REGS*BYTE_W-1:0]  reg_bank
);
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic [BYTE_W-1:0] rd_data;
    logic [BYTE_W-1:0] len_data;
    logic [BYTE_W-1:0] raddr;
    smb_wr_t           wr_bus;
    smb_state_e        ctrl_state;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_ctrl #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_ctrl (
        .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .len_data(len_data), .wr(wr_bus),
        .raddr(raddr), .sda_oe(sda_oe), .state_o(ctrl_state)
    );

    smb_regfile #(.NUM_REGS(NUM_REGS), .COUNT_REG(COUNT_REG)) u_regs (
        .clk(clk), .rst(rst), .wr(wr_bus), .raddr(raddr),
        .rd_data(rd_data), .len_data(len_data), .bank(reg_bank)
    );
endmodule

// File: rtl/smb_checker.sv
`timescale 1ns/1ps
module smb_checker
    import smb_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       sda_oe,
    input smb_state_e state,
    input smb_wr_t    wr,
    input logic       start_det,
    input logic       stop_det,
    input logic       scl_rise
);
    p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_i);

    p_oe_phase_r9: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> (state == S_ACKD || state == S_TX));

    p_reset_release_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !sda_oe);

    p_wr_in_bank_r5: assert property (@(posedge clk) disable iff (rst)
        wr.we |-> (32'(wr.addr) < NUM_REGS));

    p_wr_after_rise_r2: assert property (@(posedge clk) disable iff (rst)
        wr.we |-> $past(scl_rise));

    p_stop_idle_r8: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> state == S_IDLE);

    p_start_addr_r8: assert property (@(posedge clk) disable iff (rst)
        start_det |=> state == S_RX);
endmodule

bind smbus_blk_slave smb_checker #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe), .state(ctrl_state),
    .wr(wr_bus), .start_det(start_det), .stop_det(stop_det), .scl_rise(scl_rise)
);

// File: tb/test_smbus_blk_slave.sv
`timescale 1ns/1ps
module test_smbus_blk_slave;
    localparam int NREG = 16;
    localparam int LREG = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl_low = 1'b0;
    logic m_sda_low = 1'b0;
    logic scl_i;
    logic sda_i;
    logic sda_oe;
    logic [NREG*8-1:0] bank;
    logic [7:0] model [NREG];
    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    assign scl_i = !m_scl_low;
    assign sda_i = !(m_sda_low || sda_oe);

    smbus_blk_slave i_smbus_blk_slave (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .sda_oe(sda_oe), .reg_bank(bank)
    );

    task automatic q();
        repeat (10) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic chk_bank(input string req);
        for (int i = 0; i < NREG; i++)
            chk(bank[i*8 +: 8] == model[i], req, bank[i*8 +: 8], model[i]);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b1; q();
        m_scl_low = 1'b1; q();
    endtask

    task automatic bus_rstart();
        m_sda_low = 1'b0; q();
        m_scl_low = 1'b0; q();
        m_sda_low = 1'b1; q();
        m_scl_low = 1'b1; q();
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; q();
        m_scl_low = 1'b0; q();
        m_sda_low = 1'b0; q();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda_low = !b[i]; q();
            m_scl_low = 1'b0; q(); q();
            m_scl_low = 1'b1; q();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        m_sda_low = 1'b0; q();
        m_scl_low = 1'b0; q();
        acked = !sda_i; q();
        m_scl_low = 1'b1; q();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = 1'b0; q();
            m_scl_low = 1'b0; q();
            b[i] = sda_i; q();
            m_scl_low = 1'b1; q();
        end
        m_sda_low = give_ack; q();
        m_scl_low = 1'b0; q(); q();
        m_scl_low = 1'b1; q();
        m_sda_low = 1'b0;
    endtask

    task automatic t_reset();
        chk(sda_oe == 1'b0, "R10 sda released", sda_oe, 0);
        chk_bank("R10 reset bank");
    endtask

    task automatic t_block_write();
        bit a;
        logic [7:0] d [3] = '{8'hA1, 8'hB2, 8'hC3};
        bus_start();
        send_byte(8'hD2, a); chk(a, "R1 write addr ack", a, 1);
        send_byte(8'h02, a); chk(a, "R2 index ack", a, 1);
        send_byte(8'h03, a); chk(a, "R2 length ack", a, 1);
        for (int i = 0; i < 3; i++) begin
            send_byte(d[i], a); chk(a, "R2 data ack", a, 1);
            model[2+i] = d[i];
        end
        bus_stop();
        chk_bank("R2 block write");
    endtask

    task automatic t_single_write(input logic [7:0] idx, input logic [7:0] val);
        bit a;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(idx, a);
        send_byte(8'h01, a);
        send_byte(val, a); chk(a, "R2 single write ack", a, 1);
        bus_stop();
        model[idx] = val;
        chk_bank("R2 single write");
    endtask

    task automatic t_block_read();
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h03, a);
        bus_rstart();
        send_byte(8'hD3, a); chk(a, "R1 read addr ack", a, 1);
        recv_byte(1'b1, b); chk(b == model[LREG], "R6 length byte", b, model[LREG]);
        recv_byte(1'b1, b); chk(b == model[3], "R6 data 0", b, model[3]);
        recv_byte(1'b1, b); chk(b == model[4], "R6 data 1", b, model[4]);
        recv_byte(1'b0, b); chk(b == model[5], "R6 data 2", b, model[5]);
        q();
        chk(sda_oe == 1'b0, "R7 release after nack", sda_oe, 0);
        bus_stop();
    endtask

    task automatic t_early_stop();
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h02, a);
        bus_rstart();
        send_byte(8'hD3, a);
        recv_byte(1'b1, b);
        recv_byte(1'b0, b); chk(b == model[2], "R7 single byte read", b, model[2]);
        bus_stop();
        chk(sda_oe == 1'b0, "R7 idle after stop", sda_oe, 0);
    endtask

    task automatic t_bad_addr();
        bit a;
        bus_start();
        send_byte(8'hA4, a); chk(!a, "R1 foreign addr nack", a, 0);
        send_byte(8'h00, a); chk(!a, "R1 ignored after nack", a, 0);
        send_byte(8'h55, a);
        bus_stop();
        chk_bank("R1 bank unchanged");
    endtask

    task automatic t_zero_len();
        bit a;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        send_byte(8'h00, a); chk(!a, "R3 zero length nack", a, 0);
        send_byte(8'h99, a);
        bus_stop();
        chk_bank("R3 bank unchanged");
    endtask

    task automatic t_over_len();
        bit a;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'd10, a);
        send_byte(8'h01, a);
        send_byte(8'h11, a); chk(a, "R4 in-length ack", a, 1);
        send_byte(8'h22, a); chk(!a, "R4 extra byte nack", a, 0);
        bus_stop();
        model[10] = 8'h11;
        chk_bank("R4 extra not stored");
    endtask

    task automatic t_last_reg();
        bit a;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'd15, a);
        send_byte(8'h03, a);
        send_byte(8'h77, a); chk(a, "R5 last reg ack", a, 1);
        send_byte(8'h88, a); chk(!a, "R5 past end nack", a, 0);
        bus_stop();
        model[15] = 8'h77;
        chk_bank("R5 no wrap");
    endtask

    task automatic t_abort();
        bit a;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'd6, a);
        send_byte(8'h02, a);
        send_byte(8'h5A, a); chk(a, "R8 first byte ack", a, 1);
        send_bits(8'hF0, 4);
        bus_stop();
        model[6] = 8'h5A;
        chk_bank("R8 partial byte dropped");
        t_single_write(8'd9, 8'h3C);
        chk(bank[9*8 +: 8] == 8'h3C, "R8 recovery write", bank[9*8 +: 8], 8'h3C);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        q();
        t_reset();
        t_block_write();
        t_single_write(8'd8, 8'h05);
        t_block_read();
        t_early_stop();
        t_bad_addr();
        t_zero_len();
        t_over_len();
        t_last_reg();
        t_abort();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule